// File: doc/BRIEF.md
# Audio Stream Gateway Ring-Buffer Controller

This block is one stream channel of an audio DMA gateway. It tracks a circular buffer held in local memory and presents a small memory-mapped register file. Firmware sets the buffer base and size and the channel control bits. It then reports progress by writing a byte count to an increment register. It never writes an absolute position. The channel works in the playback (output) direction. Firmware increments move the write pointer, and a link-side port moves the read pointer as the link drains bytes.

Both pointers wrap at the buffer size. The block keeps the full and not-empty status and flags an overrun when the link asks for more than the buffer holds. It raises a request line while the running channel has data for the link. Two link position counters add up every accepted firmware increment. Rewriting the base or size, or clearing the enable bit, empties the ring.

Top module: `gw_buf_ctrl`

## Requirements
- R1: After reset every register reads zero and `link_req` is low.
- R2: The base register (0x04) keeps address bits 23:7 only. The size (0x08) and minimum size (0x1C) registers keep bits 23:4 only. All three read back masked.
- R3: In the control register (0x00), bits 31 (16-bit container), 26 (enable), 23 (firmware-controlled buffer) and 5 (FIFO ready) are read/write. Bits 9 (full) and 8 (not empty) are read-only. Bit 10 (overrun) is cleared only by writing 1 to it.
- R4: With enable and firmware control both set, writing N to 0x0C advances the write pointer (read at 0x14) by N modulo the buffer size. N is first limited to the free space. Free space is 0 when full, the buffer size when empty, and otherwise the read pointer minus the write pointer, plus the size when that difference is not positive. The change is visible right after the write cycle.
- R5: A write to 0x0C while enable or firmware control is clear changes no pointer and no counter.
- R6: Bit 8 reads 1 when the ring holds data. Bit 9 reads 1 when the held data equals the buffer size. Both are 0 when the ring is empty.
- R7: While enable and FIFO ready are both set, a link advance of M bytes moves the read pointer (read at 0x10) by M modulo the size. Otherwise the advance is ignored.
- R8: A link advance larger than the held data moves the read pointer only by the held data and sets overrun bit 10.
- R9: A write to 0x04 or 0x08, or a control write with bit 26 clear, returns both pointers to 0 and both flags to empty.
- R10: The link position (0x24) and link-in-buffer position (0x28) registers each add every accepted increment value, as written, modulo 2^32.
- R11: `link_req` is high exactly when enable, FIFO ready and not-empty are all set.
- R12: The pointer registers 0x10 and 0x14 are read-only; writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| link_vld | input | 1 | Link has consumed `link_bytes` this cycle |
| link_bytes | input | 24 | Byte count consumed by the link |
| link_req | output | 1 | Channel running with data available for the link |

## Verification
A register write or link advance takes effect at the clock edge that samples it. Read data is a combinational decode of the registered state. So a pointer, flag or counter result is due one edge after its stimulus. The bench drives every stimulus for a single edge, moves the address to the register of interest on the following falling edge, and samples a moment later. `link_req` is sampled at that same point.

// File: rtl/gw_pkg.sv
package gw_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PTR_W  = 24;

    // register offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_BASE  = 8'h04;
    localparam logic [7:0] OFS_SIZE  = 8'h08;
    localparam logic [7:0] OFS_FWINC = 8'h0C;
    localparam logic [7:0] OFS_RDPTR = 8'h10;
    localparam logic [7:0] OFS_WRPTR = 8'h14;
    localparam logic [7:0] OFS_SEG   = 8'h18;
    localparam logic [7:0] OFS_MINSZ = 8'h1C;
    localparam logic [7:0] OFS_LPOS  = 8'h24;
    localparam logic [7:0] OFS_LBPOS = 8'h28;

    // control/status bit positions
    localparam int B_HALF = 31;
    localparam int B_EN   = 26;
    localparam int B_FWC  = 23;
    localparam int B_OVR  = 10;
    localparam int B_FULL = 9;
    localparam int B_NE   = 8;
    localparam int B_RDY  = 5;

    // alignment of base and size fields
    localparam int BASE_LSB = 7;
    localparam int SIZE_LSB = 4;

    typedef struct packed {
        logic half;
        logic en;
        logic fwc;
        logic rdy;
    } gw_ctrl_t;

    function automatic logic [DATA_W-1:0] min32(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/gw_regs.sv
module gw_regs
    import gw_pkg::*;
#(
    parameter int AW = gw_pkg::ADDR_W,
    parameter int DW = gw_pkg::DATA_W,
    parameter int PW = gw_pkg::PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] wp,
    input  logic [PW-1:0] rp,
    input  logic          full,
    input  logic          ne,
    input  logic          ovr_evt,
    output gw_ctrl_t      ctrl,
    output logic [PW-1:0] size,
    output logic          ovr_flag,
    output logic          flush,
    output logic          inc_vld,
    output logic [DW-1:0] rdata
);

    localparam logic [PW-1:0] BASE_MASK = {{(PW-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};
    localparam logic [PW-1:0] SIZE_MASK = {{(PW-SIZE_LSB){1'b1}}, {SIZE_LSB{1'b0}}};
    localparam int            NACC      = 2;

    logic [PW-1:0] base_q, minsz_q, seg_q;
    logic [DW-1:0] acc_q [NACC];

    logic wr_ctrl;
    assign wr_ctrl = wr && (addr == OFS_CTRL);
    assign inc_vld = wr && (addr == OFS_FWINC) && ctrl.en && ctrl.fwc;
    assign flush   = wr && ((addr == OFS_BASE) || (addr == OFS_SIZE) ||
                            ((addr == OFS_CTRL) && !wdata[B_EN]));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            base_q   <= '0;
            size     <= '0;
            minsz_q  <= '0;
            seg_q    <= '0;
            ovr_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.half <= wdata[B_HALF];
                ctrl.en   <= wdata[B_EN];
                ctrl.fwc  <= wdata[B_FWC];
                ctrl.rdy  <= wdata[B_RDY];
            end
            if (wr && addr == OFS_BASE)  base_q  <= wdata[PW-1:0] & BASE_MASK;
            if (wr && addr == OFS_SIZE)  size    <= wdata[PW-1:0] & SIZE_MASK;
            if (wr && addr == OFS_MINSZ) minsz_q <= wdata[PW-1:0] & SIZE_MASK;
            if (wr && addr == OFS_SEG)   seg_q   <= wdata[PW-1:0];
            if (ovr_evt)
                ovr_flag <= 1'b1;
            else if (wr_ctrl && wdata[B_OVR])
                ovr_flag <= 1'b0;
        end
    end

    // both link position counters follow the accepted increments
    for (genvar g = 0; g < NACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)
                acc_q[g] <= '0;
            else if (inc_vld)
                acc_q[g] <= acc_q[g] + wdata;
        end
    end

    function automatic logic [DW-1:0] zx(input logic [PW-1:0] v);
        return {{(DW-PW){1'b0}}, v};
    endfunction

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTRL: begin
                rdata[B_HALF] = ctrl.half;
                rdata[B_EN]   = ctrl.en;
                rdata[B_FWC]  = ctrl.fwc;
                rdata[B_OVR]  = ovr_flag;
                rdata[B_FULL] = full;
                rdata[B_NE]   = ne;
                rdata[B_RDY]  = ctrl.rdy;
            end
            OFS_BASE:  rdata = zx(base_q);
            OFS_SIZE:  rdata = zx(size);
            OFS_RDPTR: rdata = zx(rp);
            OFS_WRPTR: rdata = zx(wp);
            OFS_SEG:   rdata = zx(seg_q);
            OFS_MINSZ: rdata = zx(minsz_q);
            OFS_LPOS:  rdata = acc_q[0];
            OFS_LBPOS: rdata = acc_q[1];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gw_ptrs.sv
module gw_ptrs
    import gw_pkg::*;
#(
    parameter int DW = gw_pkg::DATA_W,
    parameter int PW = gw_pkg::PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] size,
    input  logic          flush,
    input  logic          inc_vld,
    input  logic [DW-1:0] inc_amt,
    input  logic          lk_vld,
    input  logic [PW-1:0] lk_amt,
    output logic [PW-1:0] wp,
    output logic [PW-1:0] rp,
    output logic          full,
    output logic          ne,
    output logic          ovr_evt
);

    localparam int SW = PW + 1;

    logic [PW-1:0] free_b, held_b, n_b, m_b;
    logic [SW-1:0] wsum, rsum, held_nx;
    logic [DW-1:0] n_wide;

    function automatic logic [PW-1:0] wrap(input logic [SW-1:0] s,
                                           input logic [PW-1:0] sz);
        logic [SW-1:0] r;
        r = (s >= {1'b0, sz}) ? s - {1'b0, sz} : s;
        return r[PW-1:0];
    endfunction

    always_comb begin
        if (full)
            free_b = '0;
        else if (!ne)
            free_b = size;
        else if (rp > wp)
            free_b = rp - wp;
        else
            free_b = rp - wp + size;
        held_b  = size - free_b;

        n_wide  = min32(inc_amt, {{(DW-PW){1'b0}}, free_b});
        n_b     = inc_vld ? n_wide[PW-1:0] : '0;
        m_b     = !lk_vld ? '0 : (lk_amt > held_b) ? held_b : lk_amt;
        ovr_evt = lk_vld && (lk_amt > held_b);

        wsum    = {1'b0, wp} + {1'b0, n_b};
        rsum    = {1'b0, rp} + {1'b0, m_b};
        held_nx = {1'b0, held_b} + {1'b0, n_b} - {1'b0, m_b};
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp   <= '0;
            rp   <= '0;
            full <= 1'b0;
            ne   <= 1'b0;
        end else begin
            wp   <= wrap(wsum, size);
            rp   <= wrap(rsum, size);
            ne   <= (held_nx != '0);
            full <= (held_nx != '0) && (held_nx == {1'b0, size});
        end
    end

endmodule

// File: rtl/gw_buf_ctrl.sv
module gw_buf_ctrl
    import gw_pkg::*;
#(
    parameter int ADDR_W = gw_pkg::ADDR_W,
    parameter int DATA_W = gw_pkg::DATA_W,
    parameter int PTR_W  = gw_pkg::PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              link_vld,
    input  logic [PTR_W-1:0]  link_bytes,
    output logic              link_req
);

    gw_ctrl_t         ctrl;
    logic [PTR_W-1:0] size, wp, rp;
    logic             full, ne, ovr_evt, ovr_flag, flush, inc_vld, running;

    assign running  = ctrl.en && ctrl.rdy;
    assign link_req = running && ne;

    gw_regs #(.AW(ADDR_W), .DW(DATA_W), .PW(PTR_W)) regs_i (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .wp(wp), .rp(rp), .full(full), .ne(ne), .ovr_evt(ovr_evt),
        .ctrl(ctrl), .size(size), .ovr_flag(ovr_flag), .flush(flush),
        .inc_vld(inc_vld), .rdata(reg_rdata)
    );

    gw_ptrs #(.DW(DATA_W), .PW(PTR_W)) ptrs_i (
        .clk(clk), .rst(rst), .size(size), .flush(flush),
        .inc_vld(inc_vld), .inc_amt(reg_wdata),
        .lk_vld(link_vld && running), .lk_amt(link_bytes),
        .wp(wp), .rp(rp), .full(full), .ne(ne), .ovr_evt(ovr_evt)
    );

endmodule

// File: rtl/gw_buf_ctrl_chk.sv
module gw_buf_ctrl_chk
    import gw_pkg::*;
#(
    parameter int ADDR_W = gw_pkg::ADDR_W,
    parameter int PTR_W  = gw_pkg::PTR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              link_vld,
    input logic              en,
    input logic              fwc,
    input logic              rdy,
    input logic              flush,
    input logic              full,
    input logic              ne,
    input logic              ovr_flag,
    input logic [PTR_W-1:0]  wp,
    input logic [PTR_W-1:0]  rp,
    input logic [PTR_W-1:0]  size
);

    // R6
    full_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> ne);

    // R4
    ptr_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (size != '0) |-> (wp < size && rp < size));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!ne && !full && wp == '0 && rp == '0));

    // R5
    inc_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_FWINC && !(en && fwc)) |=> $stable(wp));

    // R7
    link_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (link_vld && !(en && rdy) && !reg_wr) |=> $stable(rp));

    // R8
    ovr_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(link_vld));

endmodule

bind gw_buf_ctrl gw_buf_ctrl_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .link_vld(link_vld), .en(ctrl.en), .fwc(ctrl.fwc), .rdy(ctrl.rdy),
    .flush(flush), .full(full), .ne(ne), .ovr_flag(ovr_flag),
    .wp(wp), .rp(rp), .size(size)
);

// File: tb/gw_buf_ctrl_tb.sv
`timescale 1ns/1ps
module gw_buf_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_vld = 1'b0;
    logic [23:0] link_bytes = '0;
    logic        link_req;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] RUN = 32'h8480_0020;

    always #2.5 clk = ~clk;

    gw_buf_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_vld(link_vld), .link_bytes(link_bytes), .link_req(link_req)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic lk(input logic [23:0] n);
        @(negedge clk);
        link_vld = 1'b1; link_bytes = n;
        @(negedge clk);
        link_vld = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a,
                          input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 8'h00, 32'h0);
        rd_chk("R1 rdptr", 8'h10, 32'h0);
        rd_chk("R1 lpos", 8'h24, 32'h0);
        check("R1 link_req", {31'b0, link_req}, 32'h0);
    endtask

    task automatic t_masks;
        wr(8'h04, 32'hFFFF_FFFF); rd_chk("R2 base", 8'h04, 32'h00FF_FF80);
        wr(8'h08, 32'hFFFF_FFFF); rd_chk("R2 size", 8'h08, 32'h00FF_FFF0);
        wr(8'h1C, 32'h0000_123F); rd_chk("R2 minsz", 8'h1C, 32'h0000_1230);
        wr(8'h04, 32'h0000_1000);
        wr(8'h08, 32'h0000_0040);
    endtask

    task automatic t_disabled_inc;
        wr(8'h00, 32'h0080_0020);          // firmware control, no enable
        wr(8'h0C, 32'd16);
        rd_chk("R5 no enable", 8'h14, 32'h0);
        wr(8'h00, 32'h0400_0020);          // enable, no firmware control
        wr(8'h0C, 32'd16);
        rd_chk("R5 no fwc", 8'h14, 32'h0);
        rd_chk("R5 lpos", 8'h24, 32'h0);
    endtask

    task automatic t_fill;
        wr(8'h00, RUN);
        rd_chk("R3 ctrl readback", 8'h00, RUN);
        wr(8'h0C, 32'd24);
        rd_chk("R4 wp 24", 8'h14, 32'd24);
        rd_chk("R6 ne", 8'h00, RUN | 32'h100);
        check("R11 link_req", {31'b0, link_req}, 32'h1);
        lk(24'd10);
        rd_chk("R7 rp 10", 8'h10, 32'd10);
        wr(8'h0C, 32'd40);                  // wraps to 0
        rd_chk("R4 wrap", 8'h14, 32'd0);
        wr(8'h0C, 32'd20);                  // only 10 free
        rd_chk("R4 saturate", 8'h14, 32'd10);
        rd_chk("R6 full", 8'h00, RUN | 32'h300);
        rd_chk("R10 lpos", 8'h24, 32'd84);
        rd_chk("R10 lbpos", 8'h28, 32'd84);
        wr(8'h14, 32'd5);
        wr(8'h10, 32'd5);
        rd_chk("R12 wp", 8'h14, 32'd10);
        rd_chk("R12 rp", 8'h10, 32'd10);
    endtask

    task automatic t_drain_overrun;
        lk(24'd64);
        rd_chk("R7 rp wrap", 8'h10, 32'd10);
        rd_chk("R6 empty", 8'h00, RUN);
        check("R11 empty", {31'b0, link_req}, 32'h0);
        wr(8'h0C, 32'd8);
        lk(24'd20);
        rd_chk("R8 rp truncated", 8'h10, 32'd18);
        rd_chk("R8 ovr", 8'h00, RUN | 32'h400);
        wr(8'h00, RUN);
        rd_chk("R3 write 0 keeps ovr", 8'h00, RUN | 32'h400);
        wr(8'h00, RUN | 32'h400);
        rd_chk("R3 w1c ovr", 8'h00, RUN);
        wr(8'h00, RUN | 32'h300);
        rd_chk("R3 ro flags", 8'h00, RUN);
    endtask

    task automatic t_not_running;
        wr(8'h00, 32'h8480_0000);          // enable kept, fifo ready off
        wr(8'h0C, 32'd8);
        lk(24'd4);
        rd_chk("R7 ignored rp", 8'h10, 32'd18);
        rd_chk("R4 wp 26", 8'h14, 32'd26);
        check("R11 not running", {31'b0, link_req}, 32'h0);
    endtask

    task automatic t_flush;
        wr(8'h00, 32'h0080_0020);
        rd_chk("R9 ctrl", 8'h00, 32'h0080_0020);
        rd_chk("R9 wp", 8'h14, 32'h0);
        rd_chk("R9 rp", 8'h10, 32'h0);
        wr(8'h00, RUN);
        wr(8'h0C, 32'd8);
        wr(8'h08, 32'h0000_0040);
        rd_chk("R9 size flush wp", 8'h14, 32'h0);
        rd_chk("R9 size flush flags", 8'h00, RUN);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masks();
        t_disabled_inc();
        t_fill();
        t_drain_overrun();
        t_not_running();
        t_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule